// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects interrupt events from up to 32 hardware sources, holds them in a cause register, and raises one combined interrupt line for every cause bit that is not blocked by the mask. Software reaches the bank through a simple single-cycle memory-mapped access port. Each source uses the same bit index in every register of the bank. A per-bit control word chooses how software clears each cause bit. With one setting, software writes a one to the bit. With the other setting, the bit clears when software reads it.

A typical handler reads the masked view to find out which enabled sources are pending. Bits configured for clear-on-read are cleared by that same read. Other bits are acknowledged by writing ones back. The mask can be loaded whole, or bits can be set and cleared one at a time through separate alias words, so no read-modify-write is needed. Software can also raise any cause bit on purpose through a write-only set word, which is useful for self-test.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset, every cause bit is 0, every control bit is 0, every mask bit is 1, and `irq_o` is low.
- R2: Registers sit at word offsets 0 to 6: control, cause, masked cause, cause set, mask value, mask set, mask clear. A read of offset 3, 5, 6 or any offset of 7 and above returns 0. A write to an offset of 7 or above changes nothing.
- R3: A 1 on bit n of `hw_evt_i` during a clock cycle sets cause bit n at that clock edge. The bit then stays set until software clears it.
- R4: A cause bit whose control bit is 0 is cleared by writing a 1 to it at offset 1 or at offset 2. Bits written as 0 are unchanged. A written 1 has no effect on bits whose control bit is 1.
- R5: Reading offset 1 returns the cause value as it was before the read. Every cause bit whose control bit is 1 is then cleared at the clock edge that ends the read.
- R6: Reading offset 2 returns cause AND NOT mask. Only the bits returned with control bit 1 are cleared. Masked cause bits keep their value.
- R7: Writing offset 3 sets every cause bit written as 1.
- R8: A write to offset 4 loads the mask with the written value. A 1 written to offset 5 sets that mask bit, and a 1 written to offset 6 clears it. Offset 4 reads back the mask.
- R9: `irq_o` is high exactly when some bit of cause AND NOT mask is 1. A mask bit of 1 blocks its source.
- R10: When a hardware event and a clear (by write or by read) hit the same cause bit in the same cycle, the bit stays set.
- R11: Offset 0 is a read/write control register. Bit n of the control register set to 1 selects clear-on-read for cause bit n, and set to 0 selects write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access valid in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word offset of the register |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Read data, valid in the read cycle |
| hw_evt_i | input | WIDTH | Per-source event strobes |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are those where a hardware event arrives in the same cycle as a clear that targets the same bit. The clear can come from a write-one or from a clear-on-read access. The bench drives the event strobe and the bus access from the same task call, so both land on one clock edge. A second hard case is a masked-view read where some cause bits are masked and others are not. The bench sets up a mixed mask with clear-on-read enabled, reads the masked view, and then reads the raw cause register. This shows that only the bits the masked read returned were cleared.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   // Word offsets; the order is part of the software contract.
   typedef enum logic [2:0] {
      OFS_CTRL   = 3'd0,
      OFS_CAUSE  = 3'd1,
      OFS_MASKED = 3'd2,
      OFS_CSET   = 3'd3,
      OFS_MVAL   = 3'd4,
      OFS_MSET   = 3'd5,
      OFS_MCLR   = 3'd6
   } reg_ofs_e;

   // Decoded access strobes, at most one write and one read active.
   typedef struct packed {
      logic ctrl_wr;
      logic cause_wr;
      logic masked_wr;
      logic cset_wr;
      logic mval_wr;
      logic mset_wr;
      logic mclr_wr;
      logic ctrl_rd;
      logic cause_rd;
      logic masked_rd;
      logic mval_rd;
   } acc_s;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output acc_s              acc_o
);

   localparam int OFS_W = 3;

   if (ADDR_W < OFS_W) begin : g_bad_addr_w
      $error("irq_bank_decode: ADDR_W must be at least 3");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_ofs_e ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic wr_en, rd_en;

   always_comb begin
      wr_en = sel_i &&  wr_i;
      rd_en = sel_i && !wr_i;
      acc_o.ctrl_wr   = wr_en && hit(addr_i, OFS_CTRL);
      acc_o.cause_wr  = wr_en && hit(addr_i, OFS_CAUSE);
      acc_o.masked_wr = wr_en && hit(addr_i, OFS_MASKED);
      acc_o.cset_wr   = wr_en && hit(addr_i, OFS_CSET);
      acc_o.mval_wr   = wr_en && hit(addr_i, OFS_MVAL);
      acc_o.mset_wr   = wr_en && hit(addr_i, OFS_MSET);
      acc_o.mclr_wr   = wr_en && hit(addr_i, OFS_MCLR);
      acc_o.ctrl_rd   = rd_en && hit(addr_i, OFS_CTRL);
      acc_o.cause_rd  = rd_en && hit(addr_i, OFS_CAUSE);
      acc_o.masked_rd = rd_en && hit(addr_i, OFS_MASKED);
      acc_o.mval_rd   = rd_en && hit(addr_i, OFS_MVAL);
   end

endmodule

// File: rtl/irq_cause_bit.sv
module irq_cause_bit (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic set_i,
   input  logic wclr_i,
   input  logic rclr_i,
   output logic q_o
);

   logic q_d;

   // Event and software set take priority over either clear path.
   always_comb begin
      q_d = (q_o && !wclr_i && !rclr_i) || evt_i || set_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= 1'b0;
      else         q_o <= q_d;
   end

   assert_evt_sticks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i |=> q_o);

   assert_set_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o);

   assert_w1c_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wclr_i && !evt_i && !set_i) |=> !q_o);

   assert_cor_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rclr_i && !evt_i && !set_i) |=> !q_o);

   assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o && !wclr_i && !rclr_i) |=> q_o);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] mask_o
);

   localparam logic [WIDTH-1:0] RESET_MASK = '1;

   logic [WIDTH-1:0] mask_d;

   always_comb begin
      mask_d = mask_o;
      if (load_i)     mask_d = wdata_i;
      else if (set_i) mask_d = mask_o | wdata_i;
      else if (clr_i) mask_d = mask_o & ~wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_o <= RESET_MASK;
      else         mask_o <= mask_d;
   end

   assert_mask_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (mask_o == $past(wdata_i)));

   assert_mask_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !load_i) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));

   assert_mask_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !load_i && !set_i) |=> ((mask_o & $past(wdata_i)) == '0));

   assert_mask_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !set_i && !clr_i) |=> $stable(mask_o));

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
   import irq_bank_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter int ADDR_W  = 3,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [WIDTH-1:0]  bus_wdata_i,
   output logic [WIDTH-1:0]  bus_rdata_o,
   input  logic [WIDTH-1:0]  hw_evt_i,
   output logic              irq_o
);

   localparam int MAX_W = 32;

   if (WIDTH < 1 || WIDTH > MAX_W) begin : g_bad_width
      $error("irq_cause_bank: WIDTH must be 1..32");
   end

   acc_s             acc;
   logic [WIDTH-1:0] ctrl_q;
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] cause_q;
   logic [WIDTH-1:0] pend;
   logic [WIDTH-1:0] wclr_vec;
   logic [WIDTH-1:0] rclr_vec;
   logic [WIDTH-1:0] set_vec;
   logic             irq_any;

   irq_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
      .sel_i  (bus_sel_i),
      .wr_i   (bus_wr_i),
      .addr_i (bus_addr_i),
      .acc_o  (acc)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ctrl_q <= '0;
      else if (acc.ctrl_wr) ctrl_q <= bus_wdata_i;
   end

   irq_mask_reg #(.WIDTH(WIDTH)) u_mask (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (acc.mval_wr),
      .set_i   (acc.mset_wr),
      .clr_i   (acc.mclr_wr),
      .wdata_i (bus_wdata_i),
      .mask_o  (mask_q)
   );

   // Clear sources, per bit, steered by the control word.
   always_comb begin
      wclr_vec = (acc.cause_wr || acc.masked_wr) ? (bus_wdata_i & ~ctrl_q) : '0;
      if (acc.cause_rd)       rclr_vec = ctrl_q;
      else if (acc.masked_rd) rclr_vec = ctrl_q & ~mask_q;
      else                    rclr_vec = '0;
      set_vec  = acc.cset_wr ? bus_wdata_i : '0;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_cause
      irq_cause_bit u_bit (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .evt_i  (hw_evt_i[i]),
         .set_i  (set_vec[i]),
         .wclr_i (wclr_vec[i]),
         .rclr_i (rclr_vec[i]),
         .q_o    (cause_q[i])
      );
   end

   assign pend    = cause_q & ~mask_q;
   assign irq_any = |pend;

   always_comb begin
      bus_rdata_o = '0;
      if (acc.ctrl_rd)   bus_rdata_o = ctrl_q;
      if (acc.cause_rd)  bus_rdata_o = cause_q;
      if (acc.masked_rd) bus_rdata_o = pend;
      if (acc.mval_rd)   bus_rdata_o = mask_q;
   end

   if (OUT_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= irq_any;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_any;

      assert_irq_rise_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(irq_o) |-> $past((|hw_evt_i) || acc.cset_wr || acc.mval_wr || acc.mclr_wr));

      assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (&mask_q) |-> !irq_o);
   end

   assert_rdata_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_sel_i |-> (bus_rdata_o == '0));

endmodule

// File: tb/irq_cause_bank_bench.sv
module irq_cause_bank_bench;

   localparam int W  = 32;
   localparam int AW = 3;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic [W-1:0]  evt = '0;
   logic          irq;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   irq_cause_bank u_irq_cause_bank (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_sel_i   (sel),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .hw_evt_i    (evt),
      .irq_o       (irq)
   );

   // Monitor: compares read data against the scoreboard queue.
   always @(negedge clk) begin
      #2;
      if (sel && !wr) begin
         exp_t e;
         n_chk++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL %s unexpected read: actual %h expected none", "R2", rdata);
         end else begin
            e = sb.pop_front();
            if (rdata !== e.exp) begin
               n_fail++;
               $display("FAIL %s read: actual %h expected %h", e.tag, rdata, e.exp);
            end
         end
      end
   end

   task automatic bus_wr(input logic [AW-1:0] a, input logic [W-1:0] d,
                         input logic [W-1:0] ev = '0);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d; evt = ev;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, input logic [W-1:0] e,
                         input string tag, input logic [W-1:0] ev = '0);
      exp_t x;
      x.exp = e; x.tag = tag;
      sb.push_back(x);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a; wdata = '0; evt = ev;
   endtask

   task automatic pulse(input logic [W-1:0] ev);
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; evt = ev;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; evt = '0;
      #2;
      n_chk++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s irq: actual %b expected %b", tag, irq, e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      bus_rd(3'd0, 32'h0, "R1");
      bus_rd(3'd1, 32'h0, "R1");
      bus_rd(3'd4, 32'hFFFF_FFFF, "R1");
      chk_irq(1'b0, "R1");
      // R2 write-only and unused offsets read zero
      bus_rd(3'd3, 32'h0, "R2");
      bus_rd(3'd5, 32'h0, "R2");
      bus_rd(3'd6, 32'h0, "R2");
      bus_rd(3'd7, 32'h0, "R2");
      bus_wr(3'd7, 32'h0000_00FF);
      bus_rd(3'd0, 32'h0, "R2");
      // R3 events latch; masked so no irq
      pulse(32'h0000_0005);
      bus_rd(3'd1, 32'h0000_0005, "R3");
      bus_rd(3'd2, 32'h0, "R6");
      chk_irq(1'b0, "R9");
      // R8 mask clear alias, R9 irq
      bus_wr(3'd6, 32'h0000_0001);
      bus_rd(3'd4, 32'hFFFF_FFFE, "R8");
      chk_irq(1'b1, "R9");
      bus_rd(3'd2, 32'h0000_0001, "R6");
      // R4 write-one-to-clear through both views
      bus_wr(3'd1, 32'h0000_0004);
      bus_rd(3'd1, 32'h0000_0001, "R4");
      bus_wr(3'd2, 32'h0000_0001);
      bus_rd(3'd1, 32'h0, "R4");
      chk_irq(1'b0, "R9");
      // R11 control
      bus_wr(3'd0, 32'h0000_00F0);
      bus_rd(3'd0, 32'h0000_00F0, "R11");
      // R7 cause set, R5 clear-on-read
      bus_wr(3'd3, 32'h0000_0030);
      bus_rd(3'd1, 32'h0000_0030, "R7");
      bus_rd(3'd1, 32'h0, "R5");
      // R4 write-one ignored on clear-on-read bits
      bus_wr(3'd3, 32'h0000_0030);
      bus_wr(3'd1, 32'h0000_0030);
      bus_rd(3'd1, 32'h0000_0030, "R4");
      // R6 masked read clears only unmasked COR bits
      bus_wr(3'd4, 32'hFFFF_FFDF);
      bus_rd(3'd4, 32'hFFFF_FFDF, "R8");
      bus_wr(3'd3, 32'h0000_0030);
      bus_rd(3'd2, 32'h0000_0020, "R6");
      bus_rd(3'd1, 32'h0000_0010, "R6");
      bus_rd(3'd1, 32'h0, "R5");
      // R8 mask set alias
      bus_wr(3'd5, 32'h0000_0020);
      bus_rd(3'd4, 32'hFFFF_FFFF, "R8");
      // R10 event beats write-one clear
      bus_wr(3'd3, 32'h0000_0001);
      bus_wr(3'd1, 32'h0000_0001, 32'h0000_0001);
      bus_rd(3'd1, 32'h0000_0001, "R10");
      bus_wr(3'd1, 32'h0000_0001);
      // R10 event beats clear-on-read
      bus_wr(3'd3, 32'h0000_0010);
      bus_rd(3'd1, 32'h0000_0010, "R10", 32'h0000_0010);
      bus_rd(3'd1, 32'h0000_0010, "R10");
      bus_rd(3'd1, 32'h0, "R5");
      // R9 top bit, then R4 clear drops irq
      pulse(32'h8000_0000);
      bus_wr(3'd6, 32'h8000_0000);
      chk_irq(1'b1, "R9");
      bus_wr(3'd1, 32'h8000_0000);
      chk_irq(1'b0, "R4");
      @(negedge clk);
      sel = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #100000;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule